// File: doc/BRIEF.md
# Idle Clock Gate and Wakeup Controller

This block puts a small 8-bit controller core into a low-power idle state and brings it back out. Software writes a one to the idle control bit. On the next clock edge the block stops the core clock and leaves the peripheral clock enable asserted, so interrupt logic, timers and the serial port keep running. The core registers receive no clock edges, so they keep their contents until wakeup.

Three sources end idle. The first is any interrupt request whose enable is set; it vectors to a slot computed from the request index. The second is a falling edge on one of the external wake pins, if the pin-wake enable is set; it vectors to a fixed address. The third is the external reset input, once it has stayed high long enough. When idle ends, the block reports the cause as a one-hot code for exactly one cycle, together with the vector the core should load. The qualified reset also goes out to the core as its reset.

Top module: `idle_wake_ctrl`

## Requirements
- R1: A cycle with `ctl_wr_i`=1 and `ctl_idle_i`=1 while not idle sets `idle_o` and clears `cpu_clk_en_o` after the next rising clock edge. A write with `ctl_idle_i`=0 leaves the block running. After power-on reset, `idle_o`=0 and `cpu_clk_en_o`=1.
- R2: `periph_clk_en_o` stays 1 in every state, including idle.
- R3: While `idle_o`=1, `cpu_clk_o` shows no rising edges. Once idle ends, it toggles with `clk_i` again.
- R4: While idle, if `int_req_i & int_en_i` is nonzero at a rising edge, idle ends at that edge. `wake_cause_o`=3'b001 (bit 0 = interrupt). `wake_vec_o`=0x0003 + 8*i, where i is the lowest set index of the masked requests.
- R5: While idle, an interrupt request whose enable bit is 0 has no effect: idle persists and no cause is reported.
- R6: While idle with `pin_wake_en_i`=1, a high-to-low change on any `wake_pins_i` bit ends idle at the third rising edge after the change. That change passes through two synchronizer stages and one edge stage. `wake_cause_o`=3'b010 (bit 1 = pin) and `wake_vec_o`=0x0023. A falling edge while `pin_wake_en_i`=0 has no effect, and a rising edge never has any effect.
- R7: `core_rst_o` rises only after `ext_rst_i` has been high for 24 consecutive rising edges. A shorter pulse has no effect. `core_rst_o` falls at the first rising edge at which `ext_rst_i` is low.
- R8: A qualified reset during idle ends idle with `wake_cause_o`=3'b100 (bit 2 = reset) and `wake_vec_o`=0x0000.
- R9: If an enabled interrupt and a qualifying pin edge are present at the same edge, the interrupt cause and vector are reported.
- R10: `wake_cause_o` is zero or one-hot, and a nonzero value lasts exactly one cycle.
- R11: When not idle, interrupts, pin edges and reset report no wake cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ext_rst_i | input | 1 | External reset request, active high, must be qualified |
| ctl_wr_i | input | 1 | Write strobe for the idle control bit |
| ctl_idle_i | input | 1 | Value written to the idle control bit |
| int_req_i | input | N_IRQ | Interrupt request lines |
| int_en_i | input | N_IRQ | Interrupt enable bits |
| pin_wake_en_i | input | 1 | Enable for pin-edge wakeup |
| wake_pins_i | input | N_PINS | Asynchronous external wake pins |
| idle_o | output | 1 | Idle control bit, 1 while idle |
| cpu_clk_en_o | output | 1 | Core clock enable |
| cpu_clk_o | output | 1 | Glitch-free gated core clock |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| core_rst_o | output | 1 | Qualified reset to the core |
| wake_cause_o | output | 3 | One-hot wake cause: bit0 interrupt, bit1 pin, bit2 reset |
| wake_vec_o | output | 16 | Vector to load on wakeup |

## Verification
The hardest case to reach is an interrupt and a pin edge that qualify at the same rising edge. The pin path trails its input by two synchronizer stages, while the interrupt acts within the cycle. The stimulus therefore drops a pin low, waits exactly two falling clock edges, and only then raises an enabled request, so both conditions meet the same edge. Reset qualification is probed at its boundary: a pulse of 23 cycles must be ignored, and a level held for 24 cycles must take effect.

// File: rtl/idle_wake_pkg.sv
package idle_wake_pkg;
  localparam int unsigned VEC_W = 16;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'b000,
    CAUSE_IRQ  = 3'b001,
    CAUSE_PIN  = 3'b010,
    CAUSE_RST  = 3'b100
  } wake_cause_e;
endpackage

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
  parameter int unsigned N_PINS = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pins_i,
  output logic              fall_o
);
  logic [N_PINS-1:0] s1_q, s2_q, prev_q;
  logic [N_PINS-1:0] fall_vec;

  // Pins idle high; reset value all ones avoids false edges after reset.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '1;
      s2_q   <= '1;
      prev_q <= '1;
    end else begin
      s1_q   <= pins_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  for (genvar g = 0; g < N_PINS; g++) begin : g_fall
    assign fall_vec[g] = prev_q[g] & ~s2_q[g];
  end

  assign fall_o = |fall_vec;
endmodule

// File: rtl/rst_qualifier.sv
module rst_qualifier #(
  parameter int unsigned RST_CYCLES = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_i,
  output logic rst_o
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(RST_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!ext_rst_i)        cnt_d = '0;
    else if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign rst_o = (cnt_q == CMAX);

  p_low_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rst_i |=> !rst_o);
  p_rise_needs_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_o) |-> $past(ext_rst_i));
endmodule

// File: rtl/irq_select.sv
module irq_select #(
  parameter int unsigned N_IRQ = 5,
  parameter int unsigned IDW   = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic [N_IRQ-1:0] req_i,
  input  logic [N_IRQ-1:0] en_i,
  output logic             hit_o,
  output logic [IDW-1:0]   idx_o
);
  logic [N_IRQ-1:0] masked;
  assign masked = req_i & en_i;
  assign hit_o  = |masked;

  // Lowest index has priority: scan from the top down.
  always_comb begin
    idx_o = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (masked[i]) idx_o = IDW'(i);
    end
  end
endmodule

// File: rtl/cpu_clk_gate.sv
module cpu_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_lat;

  // Enable is captured while the clock is low, so the AND never glitches.
  always_latch begin
    if (!clk_i) en_lat <= en_i;
  end

  assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl
  import idle_wake_pkg::*;
#(
  parameter int unsigned       N_IRQ      = 5,
  parameter int unsigned       N_PINS     = 10,
  parameter int unsigned       RST_CYCLES = 24,
  parameter logic [VEC_W-1:0]  VEC_BASE   = 16'h0003,
  parameter logic [VEC_W-1:0]  VEC_STRIDE = 16'h0008,
  parameter logic [VEC_W-1:0]  PIN_VEC    = 16'h0023,
  parameter logic [VEC_W-1:0]  RST_VEC    = 16'h0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_rst_i,
  input  logic              ctl_wr_i,
  input  logic              ctl_idle_i,
  input  logic [N_IRQ-1:0]  int_req_i,
  input  logic [N_IRQ-1:0]  int_en_i,
  input  logic              pin_wake_en_i,
  input  logic [N_PINS-1:0] wake_pins_i,
  output logic              idle_o,
  output logic              cpu_clk_en_o,
  output logic              cpu_clk_o,
  output logic              periph_clk_en_o,
  output logic              core_rst_o,
  output logic [2:0]        wake_cause_o,
  output logic [VEC_W-1:0]  wake_vec_o
);
  localparam int unsigned IDW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  logic           pin_fall, irq_hit, core_rst;
  logic [IDW-1:0] irq_idx;
  logic [VEC_W-1:0] irq_vec;

  logic             idle_q, idle_d;
  wake_cause_e      cause_q, cause_d;
  logic [VEC_W-1:0] vec_q, vec_d;

  wake_edge_det #(.N_PINS(N_PINS)) u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .pins_i(wake_pins_i), .fall_o(pin_fall)
  );

  rst_qualifier #(.RST_CYCLES(RST_CYCLES)) u_rstq (
    .clk_i (clk_i), .rst_ni(rst_ni), .ext_rst_i(ext_rst_i), .rst_o(core_rst)
  );

  irq_select #(.N_IRQ(N_IRQ), .IDW(IDW)) u_irq (
    .req_i(int_req_i), .en_i(int_en_i), .hit_o(irq_hit), .idx_o(irq_idx)
  );

  assign irq_vec = VEC_BASE + VEC_STRIDE * VEC_W'(irq_idx);

  always_comb begin
    idle_d  = idle_q;
    cause_d = CAUSE_NONE;
    vec_d   = vec_q;
    if (core_rst) begin
      idle_d = 1'b0;
      if (idle_q) begin
        cause_d = CAUSE_RST;
        vec_d   = RST_VEC;
      end
    end else if (idle_q) begin
      if (irq_hit) begin
        idle_d  = 1'b0;
        cause_d = CAUSE_IRQ;
        vec_d   = irq_vec;
      end else if (pin_fall && pin_wake_en_i) begin
        idle_d  = 1'b0;
        cause_d = CAUSE_PIN;
        vec_d   = PIN_VEC;
      end
    end else if (ctl_wr_i && ctl_idle_i) begin
      idle_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q  <= 1'b0;
      cause_q <= CAUSE_NONE;
      vec_q   <= '0;
    end else begin
      idle_q  <= idle_d;
      cause_q <= cause_d;
      vec_q   <= vec_d;
    end
  end

  cpu_clk_gate u_gate (.clk_i(clk_i), .en_i(!idle_q), .gclk_o(cpu_clk_o));

  assign idle_o          = idle_q;
  assign cpu_clk_en_o    = !idle_q;
  assign periph_clk_en_o = 1'b1;
  assign core_rst_o      = core_rst;
  assign wake_cause_o    = cause_q;
  assign wake_vec_o      = vec_q;

  p_enter_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && ctl_wr_i && ctl_idle_i && !core_rst_o) |=> (idle_o && !cpu_clk_en_o));
  p_irq_wake_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && irq_hit && !core_rst_o) |=> (!idle_o && wake_cause_o == 3'b001));
  p_masked_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && !irq_hit && !pin_fall && !core_rst_o) |=> idle_o);
  p_pin_wake_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && !irq_hit && pin_fall && pin_wake_en_i && !core_rst_o)
      |=> (wake_cause_o == 3'b010 && wake_vec_o == PIN_VEC));
  p_rst_wake_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && core_rst_o) |=> (!idle_o && wake_cause_o == 3'b100));
  p_irq_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && irq_hit && pin_fall && pin_wake_en_i && !core_rst_o)
      |=> wake_cause_o == 3'b001);
  p_cause_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wake_cause_o));
  p_cause_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_cause_o != 3'b000) |=> (wake_cause_o == 3'b000));
  p_awake_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o |=> (wake_cause_o == 3'b000));
endmodule

// File: tb/idle_wake_ctrl_tb.sv
module idle_wake_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_IRQ = 5;
  localparam int N_PINS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_rst = 1'b0, ctl_wr = 1'b0, ctl_idle = 1'b0, pin_en = 1'b0;
  logic [N_IRQ-1:0]  int_req = '0, int_en = '0;
  logic [N_PINS-1:0] pins = '1;
  logic idle, cpu_en, cpu_clk, per_en, core_rst;
  logic [2:0]  cause;
  logic [15:0] vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_wake_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_i(ext_rst), .ctl_wr_i(ctl_wr),
    .ctl_idle_i(ctl_idle), .int_req_i(int_req), .int_en_i(int_en),
    .pin_wake_en_i(pin_en), .wake_pins_i(pins), .idle_o(idle),
    .cpu_clk_en_o(cpu_en), .cpu_clk_o(cpu_clk), .periph_clk_en_o(per_en),
    .core_rst_o(core_rst), .wake_cause_o(cause), .wake_vec_o(vec)
  );

  int checks = 0;
  int fails  = 0;
  int cpu_edges = 0;

  typedef struct {
    logic [2:0]  c;
    logic [15:0] v;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always @(posedge cpu_clk) cpu_edges++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_wake(input logic [2:0] c, input logic [15:0] v,
                             input string tag);
    exp_t e;
    e.c = c; e.v = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic enter_idle();
    ctl_wr = 1'b1; ctl_idle = 1'b1;
    tick(1);
    ctl_wr = 1'b0; ctl_idle = 1'b0;
    chk(idle === 1'b1 && cpu_en === 1'b0, "R1 enter", {idle, cpu_en}, 2'b10);
  endtask

  // Monitor: every reported cause must match the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && cause !== 3'b000) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R11 unexpected wake", cause, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cause === e.c, {e.tag, " cause"}, cause, e.c);
        chk(vec === e.v, {e.tag, " vector"}, vec, e.v);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int e0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk(idle === 1'b0 && cpu_en === 1'b1, "R1 reset state", {idle, cpu_en}, 2'b01);
    chk(cause === 3'b000 && core_rst === 1'b0, "R10 reset quiet", {cause, core_rst}, 0);
    chk(per_en === 1'b1, "R2 running", per_en, 1);

    // R1: write with the idle bit clear does nothing
    ctl_wr = 1'b1; ctl_idle = 1'b0;
    tick(1);
    ctl_wr = 1'b0;
    tick(1);
    chk(idle === 1'b0, "R1 zero write", idle, 0);

    // R3/R2 inside idle
    enter_idle();
    e0 = cpu_edges;
    tick(6);
    chk(cpu_edges == e0, "R3 no cpu edges", cpu_edges, e0);
    chk(per_en === 1'b1, "R2 idle", per_en, 1);

    // R5: request without enable
    int_req = 5'b00010;
    tick(4);
    chk(idle === 1'b1, "R5 masked", idle, 1);

    // R4: enable index 1 -> 0x000B
    expect_wake(3'b001, 16'h000B, "R4 irq1");
    int_en = '1;
    tick(1);
    chk(idle === 1'b0, "R4 wake", idle, 0);
    int_req = '0;
    e0 = cpu_edges;
    tick(3);
    chk(cpu_edges > e0, "R3 clock resumes", cpu_edges, e0 + 3);

    // R4: lowest index of several wins -> index 2 -> 0x0013
    enter_idle();
    expect_wake(3'b001, 16'h0013, "R4 irq2");
    int_req = 5'b01100;
    tick(1);
    chk(idle === 1'b0, "R4 multi wake", idle, 0);
    int_req = '0;
    tick(2);

    // R6: pin edge ignored without enable, rising edge ignored
    enter_idle();
    pin_en = 1'b0;
    pins[3] = 1'b0;
    tick(5);
    chk(idle === 1'b1, "R6 edge disabled", idle, 1);
    pin_en = 1'b1;
    pins[3] = 1'b1;
    tick(5);
    chk(idle === 1'b1, "R6 rising ignored", idle, 1);
    expect_wake(3'b010, 16'h0023, "R6 pin9");
    pins[9] = 1'b0;
    tick(2);
    chk(idle === 1'b1, "R6 sync latency", idle, 1);
    tick(1);
    chk(idle === 1'b0, "R6 pin wake", idle, 0);
    pins[9] = 1'b1;
    tick(4);

    // R11: sources while awake report nothing
    pins[5] = 1'b0;
    int_req = 5'b00001;
    tick(6);
    chk(idle === 1'b0 && cause === 3'b000, "R11 awake", {idle, cause}, 0);
    pins[5] = 1'b1;
    int_req = '0;
    tick(4);

    // R9: interrupt and pin edge meet the same edge
    enter_idle();
    expect_wake(3'b001, 16'h0003, "R9 priority");
    pins[0] = 1'b0;
    tick(2);
    int_req = 5'b00001;
    tick(1);
    chk(idle === 1'b0, "R9 wake", idle, 0);
    int_req = '0;
    pins[0] = 1'b1;
    tick(4);

    // R7: 23-cycle pulse ignored
    enter_idle();
    ext_rst = 1'b1;
    tick(23);
    ext_rst = 1'b0;
    chk(core_rst === 1'b0, "R7 short pulse", core_rst, 0);
    tick(2);
    chk(idle === 1'b1 && core_rst === 1'b0, "R7 still idle", {idle, core_rst}, 2'b10);

    // R8: full 24-cycle qualification wakes with reset cause
    expect_wake(3'b100, 16'h0000, "R8 reset");
    ext_rst = 1'b1;
    tick(23);
    chk(core_rst === 1'b0, "R7 boundary 23", core_rst, 0);
    tick(1);
    chk(core_rst === 1'b1, "R7 boundary 24", core_rst, 1);
    tick(1);
    chk(idle === 1'b0, "R8 idle cleared", idle, 0);
    tick(3);
    ext_rst = 1'b0;
    tick(1);
    chk(core_rst === 1'b0, "R7 release", core_rst, 0);
    tick(3);

    chk(sb.size() == 0, "R10 all wakes seen", sb.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule